// File: doc/BRIEF.md
# Test Mode Qualifier with Digital Loopback

This block sits beside a four-channel PCM codec core. It takes a test-enable input, one power-down request per channel and a 2-bit mode selector. From these it derives each channel's power state and the test mode that channel runs in. An input pattern is acted on only after it has stayed unchanged for a qualifying number of clock cycles. Any change inside that window starts the count again, so glitches and partial updates on the control pins never reach the channels.

When the qualified pattern has test-enable high, the power-down inputs stop acting as power controls. Exactly one low request selects that channel for test, and all requests low select every channel. The power state of every channel stays frozen while test mode lasts. A selected channel that was already powered down stays out of test.

The digital loopback path returns each received PCM byte, bit for bit, as the transmit byte of the same channel. It sends zero until the first byte arrives after loopback is entered. Analog loopback and DC conversion are reported only as mode codes, for the analog side of the channel to act on.

Top module: `test_mode_ctl`

## Requirements
- R1: A pattern {test_en, pd_req, mode_sel} has no effect on pwr_up or ch_mode until the 17th rising clock edge at which it is present (QUAL_CYC=16 edges of stability, then the update edge); it takes effect at that edge.
- R2: A change of any of these inputs before the pattern qualifies restarts the count, so a pattern held for fewer than 17 edges never takes effect.
- R3: With a qualified pattern that has test_en=0, pwr_up[i] equals the inverse of pd_req[i] (pd_req 1 = power down), and every ch_mode field is 00.
- R4: With a qualified test_en=1 pattern, the selected channels are as follows: when exactly one pd_req bit is 0, only channel k at that index; when pd_req is 0000, all four channels; otherwise no channel. Each selected, powered-up channel gets ch_mode[2i+1:2i] = mode_sel (00 none, 01 digital loopback, 10 analog loopback, 11 DC conversion), and every other channel gets 00.
- R5: While the applied pattern has test_en=1, pwr_up keeps the value it had when test mode was entered, for every channel, whatever pd_req does.
- R6: A channel with pwr_up=0 always reports ch_mode 00, even when the test pattern selects it.
- R7: A qualified test_en=0 pattern after test mode ends all test modes and restores power control from pd_req.
- R8: In mode 01, tx_byte_out[8i+7:8i] equals the rx_byte slice captured at the last rising edge with rx_stb[i]=1, from that edge on. In any other mode, tx_byte_out passes tx_byte_in through.
- R9: After a channel enters mode 01, its tx_byte_out is zero until its first rx_stb.
- R10: During and after reset, pwr_up is 0000, ch_mode is all 00, and tx_byte_out equals tx_byte_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Test-mode enable |
| pd_req | input | 4 | Per-channel power-down request, 1 = down; channel select in test |
| mode_sel | input | 2 | Test mode type: 01 digital loopback, 10 analog loopback, 11 DC conversion |
| rx_stb | input | 4 | Per-channel strobe: received byte valid |
| rx_byte | input | 32 | Received bytes, channel i at [8i+7:8i] |
| tx_byte_in | input | 32 | Normal transmit bytes, channel i at [8i+7:8i] |
| pwr_up | output | 4 | Per-channel power-up state |
| ch_mode | output | 8 | Per-channel test mode, channel i at [2i+1:2i] |
| tx_byte_out | output | 32 | Transmit bytes after the loopback selection |

## Verification
Directed patterns cover all four single-channel selects, the all-low select and an invalid two-low select, so a wrong select decode shows up. They also cover entering test with one channel already down, which separates the freeze of power state from the suppression of test mode on a down channel. A pattern interrupted after ten cycles shows whether the count really restarts: the output must still hold the older configuration one edge before the replacement qualifies. Random patterns and random receive strobes, checked against a bench model of the requirements, exercise test-to-test transitions and the zero-then-echo behaviour of the loopback.

// File: rtl/tmq_pkg.sv
package tmq_pkg;
  typedef enum logic [1:0] {
    TM_NONE = 2'b00,
    TM_DLB  = 2'b01,
    TM_ALB  = 2'b10,
    TM_DCC  = 2'b11
  } tm_mode_e;
endpackage

// File: rtl/tmq_rst_sync.sv
module tmq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/tmq_stable_filter.sv
module tmq_stable_filter #(
  parameter int W        = 7,
  parameter int QUAL_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] pat,
  output logic         apply
);
  localparam int CW = $clog2(QUAL_CYC + 1);

  logic [W-1:0]  smp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          same;

  always_comb begin
    same  = (din == smp_q);
    apply = same && (cnt_q == CW'(QUAL_CYC - 1));
    if (!same)                         cnt_d = '0;
    else if (cnt_q == CW'(QUAL_CYC))   cnt_d = cnt_q;
    else                               cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      cnt_q <= '0;
    end else begin
      smp_q <= din;
      cnt_q <= cnt_d;
    end
  end

  assign pat = smp_q;

  // R1: one update per qualified pattern
  a_r1_single_apply: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !apply);
  // R2: an input change restarts qualification
  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (din != smp_q) |=> !apply);
endmodule

// File: rtl/tmq_cfg_decode.sv
module tmq_cfg_decode
  import tmq_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 apply,
  input  logic                 pat_test,
  input  logic [NCH-1:0]       pat_pd,
  input  logic [1:0]           pat_mode,
  output logic [NCH-1:0]       pwr_q,
  output tm_mode_e [NCH-1:0]   mode_q
);
  logic [NCH-1:0]     low_mask, sel;
  logic [NCH-1:0]     pwr_d;
  tm_mode_e [NCH-1:0] mode_d;

  always_comb begin
    low_mask = ~pat_pd;
    if (pat_pd == '0)          sel = '1;
    else if ($onehot(low_mask)) sel = low_mask;
    else                        sel = '0;

    pwr_d  = pwr_q;
    mode_d = mode_q;
    if (apply) begin
      if (!pat_test) begin
        pwr_d = low_mask;
        for (int i = 0; i < NCH; i++) mode_d[i] = TM_NONE;
      end else begin
        for (int i = 0; i < NCH; i++)
          mode_d[i] = (sel[i] && pwr_q[i]) ? tm_mode_e'(pat_mode) : TM_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= TM_NONE;
    end else begin
      pwr_q  <= pwr_d;
      mode_q <= mode_d;
    end
  end

  // R1: configuration moves only on a qualified update
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(pwr_q) && $stable(mode_q)));
  // R5: power state frozen across test patterns
  a_r5_pwr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && pat_test) |=> $stable(pwr_q));
  // R7: normal pattern restores power control from the requests
  a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !pat_test) |=> (pwr_q == ~$past(pat_pd)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R6: powered-down channel never carries a test mode
    a_r6_down_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_q[g] |-> (mode_q[g] == TM_NONE));
  end
endmodule

// File: rtl/tmq_loopback.sv
module tmq_loopback #(
  parameter int NCH  = 4,
  parameter int BW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    dlb,
  input  logic [NCH-1:0]    rx_stb,
  input  logic [NCH*BW-1:0] rx_byte,
  input  logic [NCH*BW-1:0] tx_in,
  output logic [NCH*BW-1:0] tx_out
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [BW-1:0] lb_q, lb_d;

    always_comb begin
      if (!dlb[g])        lb_d = '0;
      else if (rx_stb[g]) lb_d = rx_byte[g*BW +: BW];
      else                lb_d = lb_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lb_q <= '0;
      else        lb_q <= lb_d;
    end

    assign tx_out[g*BW +: BW] = dlb[g] ? lb_q : tx_in[g*BW +: BW];

    // R8: received byte echoed bit-exact on the next cycle
    a_r8_echo: assert property (@(posedge clk) disable iff (!rst_n)
      (dlb[g] && rx_stb[g]) |=>
        (!dlb[g] || (tx_out[g*BW +: BW] == $past(rx_byte[g*BW +: BW]))));
    // R9: loopback starts with a zero byte
    a_r9_zero_entry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dlb[g]) |-> (tx_out[g*BW +: BW] == '0));
  end
endmodule

// File: rtl/test_mode_ctl.sv
module test_mode_ctl
  import tmq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int BW       = 8,
  parameter int QUAL_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic [NCH-1:0]    pd_req,
  input  logic [1:0]        mode_sel,
  input  logic [NCH-1:0]    rx_stb,
  input  logic [NCH*BW-1:0] rx_byte,
  input  logic [NCH*BW-1:0] tx_byte_in,
  output logic [NCH-1:0]    pwr_up,
  output logic [2*NCH-1:0]  ch_mode,
  output logic [NCH*BW-1:0] tx_byte_out
);
  localparam int PW = 1 + NCH + 2;

  logic               rst_n_s;
  logic [PW-1:0]      pat;
  logic               apply;
  tm_mode_e [NCH-1:0] mode_w;
  logic [NCH-1:0]     dlb;

  tmq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  tmq_stable_filter #(.W(PW), .QUAL_CYC(QUAL_CYC)) u_filt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .din   ({test_en, pd_req, mode_sel}),
    .pat   (pat),
    .apply (apply)
  );

  tmq_cfg_decode #(.NCH(NCH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .apply    (apply),
    .pat_test (pat[PW-1]),
    .pat_pd   (pat[2 +: NCH]),
    .pat_mode (pat[1:0]),
    .pwr_q    (pwr_up),
    .mode_q   (mode_w)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_map
    assign dlb[g]            = (mode_w[g] == TM_DLB);
    assign ch_mode[2*g +: 2] = mode_w[g];
  end

  tmq_loopback #(.NCH(NCH), .BW(BW)) u_lb (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .dlb     (dlb),
    .rx_stb  (rx_stb),
    .rx_byte (rx_byte),
    .tx_in   (tx_byte_in),
    .tx_out  (tx_byte_out)
  );
endmodule

// File: tb/tb_test_mode_ctl.sv
module tb_test_mode_ctl;
  localparam int NCH = 4;
  localparam int BW  = 8;

  logic              clk;
  logic              rst_n;
  logic              test_en;
  logic [NCH-1:0]    pd_req;
  logic [1:0]        mode_sel;
  logic [NCH-1:0]    rx_stb;
  logic [NCH*BW-1:0] rx_byte;
  logic [NCH*BW-1:0] tx_byte_in;
  logic [NCH-1:0]    pwr_up;
  logic [2*NCH-1:0]  ch_mode;
  logic [NCH*BW-1:0] tx_byte_out;

  int n_chk;
  int n_fail;
  bit done;

  logic [NCH-1:0]    m_pwr;
  logic [2*NCH-1:0]  m_mode;
  logic [NCH*BW-1:0] m_lb;

  test_mode_ctl dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .pd_req(pd_req),
    .mode_sel(mode_sel), .rx_stb(rx_stb), .rx_byte(rx_byte),
    .tx_byte_in(tx_byte_in), .pwr_up(pwr_up), .ch_mode(ch_mode),
    .tx_byte_out(tx_byte_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NCH*BW-1:0] exp_tx();
    logic [NCH*BW-1:0] r;
    for (int c = 0; c < NCH; c++)
      r[c*BW +: BW] = (m_mode[2*c +: 2] == 2'b01) ? m_lb[c*BW +: BW]
                                                  : tx_byte_in[c*BW +: BW];
    return r;
  endfunction

  task automatic check_all(input string tp, input string tm, input string tx);
    chk(tp, "pwr_up", 32'(pwr_up), 32'(m_pwr));
    chk(tm, "ch_mode", 32'(ch_mode), 32'(m_mode));
    chk(tx, "tx_byte_out", 32'(tx_byte_out), 32'(exp_tx()));
  endtask

  // model of the requirements R3, R4, R5, R6, R7, R9
  task automatic model_upd(input logic t, input logic [NCH-1:0] pd,
                           input logic [1:0] m);
    logic [NCH-1:0] sel;
    if (!t) begin
      m_pwr  = ~pd;
      m_mode = '0;
    end else begin
      if (pd == '0)                 sel = '1;
      else if ($countones(~pd) == 1) sel = ~pd;
      else                           sel = '0;
      for (int c = 0; c < NCH; c++)
        m_mode[2*c +: 2] = (sel[c] && m_pwr[c]) ? m : 2'b00;
    end
    for (int c = 0; c < NCH; c++)
      if (m_mode[2*c +: 2] != 2'b01) m_lb[c*BW +: BW] = '0;
  endtask

  task automatic apply_pat(input logic t, input logic [NCH-1:0] pd,
                           input logic [1:0] m, input string told,
                           input string tp, input string tm);
    @(negedge clk);
    test_en = t; pd_req = pd; mode_sel = m;
    tx_byte_in = $urandom();
    repeat (16) @(posedge clk);
    @(negedge clk);
    check_all(told, told, told);
    @(posedge clk);
    @(negedge clk);
    model_upd(t, pd, m);
    check_all(tp, tm, "R9");
  endtask

  task automatic lb_burst(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_stb     = NCH'($urandom());
      rx_byte    = $urandom();
      tx_byte_in = $urandom();
      @(posedge clk);
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if (rx_stb[c] && m_mode[2*c +: 2] == 2'b01)
          m_lb[c*BW +: BW] = rx_byte[c*BW +: BW];
      chk("R8", "tx_byte_out", 32'(tx_byte_out), 32'(exp_tx()));
      rx_stb = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    test_en = 1'b0; pd_req = '1; mode_sel = 2'b00;
    rx_stb = '0; rx_byte = '0; tx_byte_in = 32'hA5C3_5A3C;
    m_pwr = '0; m_mode = '0; m_lb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R10", "R10", "R10");
    rst_n = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check_all("R10", "R10", "R10");

    // normal mode, all up
    apply_pat(1'b0, 4'b0000, 2'b00, "R1", "R3", "R3");
    // all channels digital loopback
    apply_pat(1'b1, 4'b0000, 2'b01, "R1", "R5", "R4");
    lb_burst(8);
    // channel 1 analog loopback, others frozen up
    apply_pat(1'b1, 4'b1101, 2'b10, "R1", "R5", "R4");
    // exit with channel 2 powered down
    apply_pat(1'b0, 4'b0100, 2'b00, "R1", "R7", "R7");
    // all-channel DC conversion: channel 2 stays out
    apply_pat(1'b1, 4'b0000, 2'b11, "R1", "R5", "R6");
    // select channel 2 alone while it is down
    apply_pat(1'b1, 4'b1011, 2'b01, "R1", "R5", "R6");
    // channel 0 digital loopback
    apply_pat(1'b1, 4'b1110, 2'b01, "R1", "R5", "R4");
    lb_burst(6);
    // channel 3 DC conversion
    apply_pat(1'b1, 4'b0111, 2'b11, "R1", "R5", "R4");
    // two low requests select nothing
    apply_pat(1'b1, 4'b0011, 2'b01, "R1", "R5", "R4");
    // exit, all up
    apply_pat(1'b0, 4'b0000, 2'b00, "R1", "R7", "R7");

    // interrupted pattern never applies
    @(negedge clk);
    test_en = 1'b1; pd_req = 4'b0000; mode_sel = 2'b01;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check_all("R2", "R2", "R2");
    apply_pat(1'b0, 4'b0010, 2'b00, "R2", "R3", "R3");

    for (int it = 0; it < 60; it++) begin
      logic t;
      logic [NCH-1:0] pd;
      logic [1:0] m;
      int r;
      t = 1'($urandom());
      m = 2'($urandom());
      r = int'($urandom() % 4);
      if (r == 0)      pd = '0;
      else if (r == 1) pd = ~(NCH'(1) << ($urandom() % NCH));
      else             pd = NCH'($urandom());
      apply_pat(t, pd, m, "R1", t ? "R5" : "R3", t ? "R4" : "R3");
      lb_burst(3);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule